// File: doc/BRIEF.md
# Tagged Free-List Frame Allocator

This block hands out and takes back fixed-size memory frames. A small table in word-addressed memory holds one list-head word for each frame-size class. Free frames of a class are chained through their first word. An allocate command names a size class and gets back either the address of a frame taken from the front of that chain, or a failure with a trap parameter that software can act on. A free command names a frame. The block reads the size class from the header word just below the frame and pushes the frame back onto the front of that class's chain.

The low two bits of every list-head word are a tag. The tag marks the word as a frame address, as an empty list, or as a redirect to another size class. A redirect lets several classes share one pool. The block serves one command at a time over a valid/acknowledge pair. It reaches memory through a single-port synchronous master port, and read data from that port comes back one cycle after the address.

Top module: `frame_pool_alloc`

## Requirements
- R1: After reset, `ack` is low and `mem_en` stays low until a command is accepted.
- R2: The list head for class `c` is read at `AV_BASE + c` (default `AV_BASE` = 0x0100). Only bits [7:0] of `req_arg` form the class of an allocate command.
- R3: If the head word has tag bits [1:0] = 00, the word is the frame address. The block reads that frame's word 0, writes it into the head, and acknowledges with `fail`=0 and `result` = frame address. With no redirects, `ack` rises 3 clock edges after the accepting edge.
- R4: If the head tag is 01, the list is empty. The block acknowledges with `fail`=1 and `result` = (requested class × 4), zero-extended. With no redirects, `ack` rises 2 edges after the accepting edge.
- R5: If the head tag is 10, bits [9:2] of the head word become the new class and the lookup repeats. Each redirect adds 2 edges to the latency.
- R6: A head tag of 11 behaves exactly like tag 10.
- R7: An allocate follows at most 8 redirects. If it meets a further redirect, it fails with the trap parameter of the original class, 18 edges after acceptance.
- R8: A free command (`req_free`=1) reads the class from bits [7:0] of the word at frame−1. It writes the current head into word 0 of the frame, then writes the frame address into the head. It acknowledges with `fail`=0 and `result` = frame address, 4 edges after acceptance.
- R9: The block accepts a command only while idle. `req_valid` raised while a command is in progress is ignored. `ack` is a single-cycle pulse.
- R10: A memory write drives `mem_en` and `mem_we` together. Read data is taken from `mem_rdata` in the cycle after the read address is driven.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Command present; accepted when idle |
| req_free | input | 1 | 1 = free a frame, 0 = allocate |
| req_arg | input | 16 | Size class (allocate) or frame address (free) |
| ack | output | 1 | One-cycle completion pulse |
| fail | output | 1 | Allocation failed (valid with ack) |
| result | output | 16 | Frame address or trap parameter (valid with ack) |
| mem_en | output | 1 | Memory access strobe |
| mem_we | output | 1 | Memory write enable |
| mem_addr | output | 16 | Memory word address |
| mem_wdata | output | 16 | Memory write data |
| mem_rdata | input | 16 | Memory read data, one cycle after address |

## Verification
Each command has a fixed latency, counted in clock edges from the accepting edge to the edge that raises `ack`:
- an allocate that finds a frame takes 3 + 2r edges, where r is the number of redirects followed;
- an allocate that finds an empty list takes 2 + 2r edges;
- an allocate that runs out of redirects takes 18 edges;
- a free takes 4 edges.

When the driver issues a command, it records the edge count plus the expected latency in the scoreboard entry. The monitor samples on the falling edge and compares the cycle at which `ack` arrives, as well as the fail flag and the result. After free commands and ignored requests, the bench also inspects the list heads and frame links in its own memory model.

// File: rtl/fpa_pkg.sv
package fpa_pkg;

  parameter int unsigned WORD_W = 16;
  parameter int unsigned IDX_W  = 8;

  typedef enum logic [1:0] {
    TAG_FRAME     = 2'b00,
    TAG_EMPTY     = 2'b01,
    TAG_REDIR     = 2'b10,
    TAG_REDIR_ALT = 2'b11
  } head_tag_e;

  typedef enum logic [3:0] {
    S_IDLE,
    S_A_RD,
    S_A_EVAL,
    S_A_LINK,
    S_F_HDR,
    S_F_HEAD_RD,
    S_F_LINK,
    S_F_SET
  } seq_state_e;

  // address of the list-head word for a size class
  function automatic logic [WORD_W-1:0] head_addr(input logic [WORD_W-1:0] base,
                                                  input logic [IDX_W-1:0]  idx);
    return base + {{(WORD_W-IDX_W){1'b0}}, idx};
  endfunction

  // failure parameter: class scaled by four
  function automatic logic [WORD_W-1:0] trap_word(input logic [IDX_W-1:0] idx);
    logic [WORD_W-1:0] w;
    w = '0;
    w[IDX_W+1:0] = {idx, 2'b00};
    return w;
  endfunction

  // class named by a redirecting head word
  function automatic logic [IDX_W-1:0] redirect_idx(input logic [WORD_W-1:0] w);
    return w[IDX_W+1:2];
  endfunction

  function automatic head_tag_e tag_of(input logic [WORD_W-1:0] w);
    return head_tag_e'(w[1:0]);
  endfunction

endpackage

// File: rtl/fpa_hop_guard.sv
module fpa_hop_guard #(
  parameter int unsigned MAX_HOPS = 8,
  parameter int unsigned HOP_W    = $clog2(MAX_HOPS + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             step,
  output logic [HOP_W-1:0] hops,
  output logic             exhausted
);

  always_ff @(posedge clk) begin
    if (!rst_n)    hops <= '0;
    else if (clr)  hops <= '0;
    else if (step) hops <= hops + HOP_W'(1);
  end

  assign exhausted = (hops == HOP_W'(MAX_HOPS));

endmodule

// File: rtl/fpa_seq.sv
module fpa_seq
  import fpa_pkg::*;
#(
  parameter logic [WORD_W-1:0] AV_BASE = 16'h0100
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic              req_free,
  input  logic [WORD_W-1:0] req_arg,
  input  logic [WORD_W-1:0] mem_rdata,
  input  logic              hop_exhausted,
  output logic              hop_clr,
  output logic              hop_step,
  output logic              mem_en,
  output logic              mem_we,
  output logic [WORD_W-1:0] mem_addr,
  output logic [WORD_W-1:0] mem_wdata,
  output logic              ack,
  output logic              fail,
  output logic [WORD_W-1:0] result,
  output logic              st_idle
);

  seq_state_e        st, nxt;
  logic [IDX_W-1:0]  cur_idx, nxt_idx, org_idx;
  logic [WORD_W-1:0] frame_q, nxt_frame;
  logic              fin, fin_fail;
  logic [WORD_W-1:0] fin_res;

  assign st_idle = (st == S_IDLE);

  always_comb begin
    nxt       = st;
    nxt_idx   = cur_idx;
    nxt_frame = frame_q;
    mem_en    = 1'b0;
    mem_we    = 1'b0;
    mem_addr  = '0;
    mem_wdata = '0;
    fin       = 1'b0;
    fin_fail  = 1'b0;
    fin_res   = '0;
    hop_clr   = 1'b0;
    hop_step  = 1'b0;
    case (st)
      S_IDLE: begin
        if (req_valid) begin
          hop_clr   = 1'b1;
          nxt_idx   = req_arg[IDX_W-1:0];
          nxt_frame = req_arg;
          nxt       = req_free ? S_F_HDR : S_A_RD;
        end
      end
      S_A_RD: begin
        mem_en   = 1'b1;
        mem_addr = head_addr(AV_BASE, cur_idx);
        nxt      = S_A_EVAL;
      end
      S_A_EVAL: begin
        case (tag_of(mem_rdata))
          TAG_FRAME: begin
            mem_en    = 1'b1;
            mem_addr  = mem_rdata;
            nxt_frame = mem_rdata;
            nxt       = S_A_LINK;
          end
          TAG_EMPTY: begin
            fin      = 1'b1;
            fin_fail = 1'b1;
            fin_res  = trap_word(org_idx);
            nxt      = S_IDLE;
          end
          default: begin
            if (hop_exhausted) begin
              fin      = 1'b1;
              fin_fail = 1'b1;
              fin_res  = trap_word(org_idx);
              nxt      = S_IDLE;
            end else begin
              hop_step = 1'b1;
              nxt_idx  = redirect_idx(mem_rdata);
              nxt      = S_A_RD;
            end
          end
        endcase
      end
      S_A_LINK: begin
        mem_en    = 1'b1;
        mem_we    = 1'b1;
        mem_addr  = head_addr(AV_BASE, cur_idx);
        mem_wdata = mem_rdata;
        fin       = 1'b1;
        fin_res   = frame_q;
        nxt       = S_IDLE;
      end
      S_F_HDR: begin
        mem_en   = 1'b1;
        mem_addr = frame_q - WORD_W'(1);
        nxt      = S_F_HEAD_RD;
      end
      S_F_HEAD_RD: begin
        nxt_idx  = mem_rdata[IDX_W-1:0];
        mem_en   = 1'b1;
        mem_addr = head_addr(AV_BASE, mem_rdata[IDX_W-1:0]);
        nxt      = S_F_LINK;
      end
      S_F_LINK: begin
        mem_en    = 1'b1;
        mem_we    = 1'b1;
        mem_addr  = frame_q;
        mem_wdata = mem_rdata;
        nxt       = S_F_SET;
      end
      S_F_SET: begin
        mem_en    = 1'b1;
        mem_we    = 1'b1;
        mem_addr  = head_addr(AV_BASE, cur_idx);
        mem_wdata = frame_q;
        fin       = 1'b1;
        fin_res   = frame_q;
        nxt       = S_IDLE;
      end
      default: nxt = S_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st      <= S_IDLE;
      cur_idx <= '0;
      org_idx <= '0;
      frame_q <= '0;
      ack     <= 1'b0;
      fail    <= 1'b0;
      result  <= '0;
    end else begin
      st      <= nxt;
      cur_idx <= nxt_idx;
      frame_q <= nxt_frame;
      if (st_idle && req_valid) org_idx <= req_arg[IDX_W-1:0];
      ack <= fin;
      if (fin) begin
        fail   <= fin_fail;
        result <= fin_res;
      end
    end
  end

endmodule

// File: rtl/frame_pool_alloc.sv
module frame_pool_alloc
  import fpa_pkg::*;
#(
  parameter logic [WORD_W-1:0] AV_BASE  = 16'h0100,
  parameter int unsigned       MAX_HOPS = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic              req_free,
  input  logic [WORD_W-1:0] req_arg,
  output logic              ack,
  output logic              fail,
  output logic [WORD_W-1:0] result,
  output logic              mem_en,
  output logic              mem_we,
  output logic [WORD_W-1:0] mem_addr,
  output logic [WORD_W-1:0] mem_wdata,
  input  logic [WORD_W-1:0] mem_rdata
);

  localparam int unsigned HOP_W = $clog2(MAX_HOPS + 1);

  logic             hop_clr, hop_step, hop_exhausted;
  logic [HOP_W-1:0] hop_cnt;
  logic             st_idle;

  fpa_hop_guard #(.MAX_HOPS(MAX_HOPS), .HOP_W(HOP_W)) u_hops (
    .clk       (clk),
    .rst_n     (rst_n),
    .clr       (hop_clr),
    .step      (hop_step),
    .hops      (hop_cnt),
    .exhausted (hop_exhausted)
  );

  fpa_seq #(.AV_BASE(AV_BASE)) u_seq (
    .clk           (clk),
    .rst_n         (rst_n),
    .req_valid     (req_valid),
    .req_free      (req_free),
    .req_arg       (req_arg),
    .mem_rdata     (mem_rdata),
    .hop_exhausted (hop_exhausted),
    .hop_clr       (hop_clr),
    .hop_step      (hop_step),
    .mem_en        (mem_en),
    .mem_we        (mem_we),
    .mem_addr      (mem_addr),
    .mem_wdata     (mem_wdata),
    .ack           (ack),
    .fail          (fail),
    .result        (result),
    .st_idle       (st_idle)
  );

endmodule

// File: rtl/fpa_checker.sv
module fpa_checker #(
  parameter int unsigned MAX_HOPS = 8,
  parameter int unsigned HOP_W    = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic             req_valid,
  input logic             ack,
  input logic             mem_en,
  input logic             mem_we,
  input logic             st_idle,
  input logic [HOP_W-1:0] hop_cnt
);

  // R9
  ack_single_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ack |=> !ack);

  // R9
  accept_leaves_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st_idle && req_valid) |=> !st_idle);

  // R10
  write_has_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> mem_en);

  // R1
  idle_no_access_chk: assert property (@(posedge clk) disable iff (!rst_n)
    st_idle |-> !mem_en);

  // R7
  hop_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hop_cnt <= HOP_W'(MAX_HOPS));

endmodule

bind frame_pool_alloc fpa_checker #(.MAX_HOPS(MAX_HOPS), .HOP_W(HOP_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .req_valid (req_valid),
  .ack       (ack),
  .mem_en    (mem_en),
  .mem_we    (mem_we),
  .st_idle   (st_idle),
  .hop_cnt   (hop_cnt)
);

// File: tb/tb_frame_pool_alloc.sv
module tb_frame_pool_alloc;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_free = 1'b0;
  logic [15:0] req_arg = '0;
  logic        ack, fail, mem_en, mem_we;
  logic [15:0] result, mem_addr, mem_wdata;
  logic [15:0] mem_rdata = '0;

  logic [15:0] mem [0:1023];
  int cyc = 0;
  int n_chk = 0;
  int n_bad = 0;

  typedef struct {
    logic        f;
    logic [15:0] res;
    int          due;
    string       rq;
  } exp_t;
  exp_t sb[$];

  always #10 clk = ~clk;   // 50 MHz

  frame_pool_alloc dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_free(req_free),
    .req_arg(req_arg), .ack(ack), .fail(fail), .result(result),
    .mem_en(mem_en), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_rdata(mem_rdata)
  );

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (mem_en) begin
      if (mem_we) mem[mem_addr[9:0]] <= mem_wdata;
      else        mem_rdata <= mem[mem_addr[9:0]];
    end
  end

  task automatic chk(input bit ok, input string rq, input string what,
                     input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s actual=0x%0h expected=0x%0h", rq, what, act, exp);
    end
  endtask

  // monitor: pops the scoreboard on each acknowledge
  always @(negedge clk) begin
    if (rst_n && ack) begin
      if (sb.size() == 0) begin
        chk(1'b0, "R9", "unexpected ack", 1, 0);
      end else begin
        exp_t e;
        e = sb.pop_front();
        chk(fail == e.f, e.rq, "fail flag", int'(fail), int'(e.f));
        chk(result == e.res, e.rq, "result", int'(result), int'(e.res));
        chk(cyc == e.due, e.rq, "ack cycle", cyc, e.due);
      end
    end
  end

  task automatic issue(input bit is_free, input logic [15:0] arg, input bit ef,
                       input logic [15:0] er, input int lat, input string rq);
    exp_t e;
    @(posedge clk); #2;
    req_valid = 1'b1; req_free = is_free; req_arg = arg;
    e.f = ef; e.res = er; e.due = cyc + 1 + lat; e.rq = rq;
    sb.push_back(e);
    @(posedge clk); #2;
    req_valid = 1'b0;
    while (sb.size() != 0) @(negedge clk);
  endtask

  initial begin
    #(20 * 200000);
    n_bad++; n_chk++;
    $display("FAIL watchdog expired actual=0x0 expected=0x1");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    for (int i = 0; i < 1024; i++) mem[i] = 16'h0000;
    mem[16'h100] = 16'h0200;              // class 0: 0x200 -> 0x210 -> empty
    mem[16'h200] = 16'h0210;
    mem[16'h210] = 16'h0001;
    mem[16'h1FF] = 16'h0000;              // header of 0x200
    mem[16'h20F] = 16'hAB00;              // header of 0x210, class 0 in low byte
    mem[16'h101] = 16'h0001;              // class 1 empty
    mem[16'h102] = 16'h0002;              // class 2 -> class 0 (tag 10)
    mem[16'h103] = 16'h0017;              // class 3 -> class 5 (tag 11)
    mem[16'h105] = 16'h0300;
    mem[16'h300] = 16'h0001;
    for (int k = 9; k <= 17; k++) mem[16'h100 + k] = 16'(((k + 1) << 2) | 2);
    mem[16'h112] = 16'h0320;              // class 18
    mem[16'h320] = 16'h0001;
    mem[16'h114] = 16'(((21) << 2) | 3);  // class 20 -> 21
    mem[16'h115] = 16'(((20) << 2) | 2);  // class 21 -> 20

    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(ack == 1'b0, "R1", "ack in reset", int'(ack), 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk(ack == 1'b0, "R1", "ack after reset", int'(ack), 0);
    chk(mem_en == 1'b0, "R1", "mem_en after reset", int'(mem_en), 0);

    issue(0, 16'd0, 0, 16'h0200, 3, "R3");
    chk(mem[16'h100] == 16'h0210, "R3", "head unlinked", int'(mem[16'h100]), 16'h0210);
    issue(0, 16'd2, 0, 16'h0210, 5, "R5");
    issue(0, 16'd0, 1, 16'd0, 2, "R4");
    issue(0, 16'd1, 1, 16'd4, 2, "R4");
    issue(1, 16'h0200, 0, 16'h0200, 4, "R8");
    chk(mem[16'h100] == 16'h0200, "R8", "head after free", int'(mem[16'h100]), 16'h0200);
    chk(mem[16'h200] == 16'h0001, "R8", "link after free", int'(mem[16'h200]), 16'h0001);
    issue(1, 16'h0210, 0, 16'h0210, 4, "R8");
    chk(mem[16'h100] == 16'h0210, "R8", "head after free2", int'(mem[16'h100]), 16'h0210);
    chk(mem[16'h210] == 16'h0200, "R8", "link after free2", int'(mem[16'h210]), 16'h0200);
    issue(0, 16'h0100, 0, 16'h0210, 3, "R2");
    chk(mem[16'h100] == 16'h0200, "R2", "class 0 head", int'(mem[16'h100]), 16'h0200);
    issue(0, 16'd3, 0, 16'h0300, 5, "R6");
    issue(0, 16'h0103, 1, 16'd12, 4, "R2");
    issue(0, 16'd10, 0, 16'h0320, 19, "R7");
    issue(0, 16'd9, 1, 16'd36, 18, "R7");
    issue(0, 16'd20, 1, 16'd80, 18, "R7");

    // R9: a second request while busy is ignored
    begin
      exp_t e;
      @(posedge clk); #2;
      req_valid = 1'b1; req_free = 1'b0; req_arg = 16'd0;
      e.f = 1'b0; e.res = 16'h0200; e.due = cyc + 1 + 3; e.rq = "R9";
      sb.push_back(e);
      @(posedge clk); #2;
      req_free = 1'b1; req_arg = 16'h0200;
      @(posedge clk); #2;
      req_valid = 1'b0; req_free = 1'b0;
      while (sb.size() != 0) @(negedge clk);
      repeat (10) @(negedge clk);
    end
    chk(mem[16'h100] == 16'h0001, "R9", "head after ignored free", int'(mem[16'h100]), 16'h0001);
    chk(mem[16'h200] == 16'h0001, "R9", "frame word untouched", int'(mem[16'h200]), 16'h0001);

    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

endmodule